// File: doc/BRIEF.md
# Timer/Event Counter with Shadowed Compare Channels

This block is a free-running up-counter with a register interface. Each count step comes from one of eight internal rates. The rates are made by a prescaler that divides the block clock by a power of two from 1 to 128. The count can instead step on qualified edges seen on timer input pin 0. Both timer input pins go through a two-flop synchronizer. Each pin then goes to an edge qualifier that can be set to ignore the pin or to react to rising, falling or both edges. The qualified edge pulses are also driven out of the block.

Each compare channel has two registers. Software writes a visible compare register. The counter is matched against a hidden shadow copy of it. While the counter is stopped, the shadow follows the visible register. While the counter is running, the shadow takes the new value only when the counter rolls over to zero, so a new compare value never takes effect in the middle of a period. A match raises a one-cycle interrupt pulse for that channel. It can also flip that channel's timer output pin.

A stopped counter is held at all ones, so the first step after enabling lands on zero. While stopped, a software read of the count returns zero.

Top module: `tmr_evt_cmp`

## Requirements
- R1: The counter is CNT_W (16) bits wide and counts up by one on each step, wrapping from all ones to zero. CTRL bit 0 is the run bit. With CTRL bit 4 clear, a step occurs once every 2^k clocks, where k is CTRL bits [3:1] (0 to 7). With CTRL bit 4 set, each qualified edge on pin 0 is one step.
- R2: While the run bit is 0, the counter is held at all ones. After the run bit is set, the first step makes the count zero.
- R3: Reading COUNT returns zero while the run bit is 0. While the run bit is 1, it returns the live count.
- R4: After reset, every register is zero. This includes the run bit, both compare registers and both shadows. The counter sits at all ones, and all interrupts and timer outputs are low.
- R5: A compare write made while the counter is stopped reaches the shadow on the next clock. A compare write made while it is running reaches the shadow only on the step that rolls the count from all ones to zero.
- R6: The shadow cannot be reached from the bus. Reading a compare address returns the last value written there.
- R7: irq[i] is high for exactly the one cycle after a step that brings the count to channel i's shadow value. The shadow value used is the one held before that step. irq[i] never rises while the counter is stopped.
- R8: Each timer pin is synchronized by two flops. EDGE bits [2p+1:2p] set the mode for pin p: 00 = none, 01 = rising, 10 = falling, 11 = both. edge_pulse[p] is high for one cycle, two clocks after the pin change has been sampled.
- R9: OUTCTL bit 2i enables output i and bit 2i+1 is its default level. When enabled, tout[i] flips each time irq[i] fires. When not enabled, tout[i] takes the default level on the next clock.
- R10: The register addresses are 0 CTRL, 1 COUNT, 2 CMP0, 3 CMP1, 4 EDGE and 5 OUTCTL. COUNT is read-only and writes to it are ignored. Other addresses read as zero, and unused register bits read as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Combinational read data for bus_addr |
| tin | input | 2 | Asynchronous timer input pins |
| edge_pulse | output | 2 | Qualified edge pulse per pin |
| irq | output | 2 | Compare-match interrupt pulse per channel |
| tout | output | 2 | Timer output pin per channel |

## Verification
The assertions assume that the bus address and write strobe are stable around each rising edge. They also assume that reset is applied before any register traffic. They place no constraint on when the timer pins change, because the synchronizer absorbs that. The stimulus changes bus signals and pins only on falling edges. It keeps the prescaler setting short so that matches and shadow updates come often. One long run at full rate covers a complete rollover, so that a compare value written mid-period can be seen taking effect only after the wrap.

// File: rtl/tmr_evt_pkg.sv
package tmr_evt_pkg;

   typedef enum logic [1:0] {
      EDGE_NONE = 2'b00,
      EDGE_RISE = 2'b01,
      EDGE_FALL = 2'b10,
      EDGE_BOTH = 2'b11
   } edge_mode_e;

   localparam int unsigned A_CTRL     = 0;
   localparam int unsigned A_COUNT    = 1;
   localparam int unsigned A_CMP_BASE = 2;

   function automatic logic edge_hit(edge_mode_e m, logic rise, logic fall);
      case (m)
         EDGE_NONE: edge_hit = 1'b0;
         EDGE_RISE: edge_hit = rise;
         EDGE_FALL: edge_hit = fall;
         default:   edge_hit = rise | fall;
      endcase
   endfunction

endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
   parameter int PRE_W = 7,
   parameter int SEL_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [SEL_W-1:0] sel,
   output logic             tick
);
   generate
      if ((2 ** SEL_W) - 1 > PRE_W) begin : g_bad
         $error("prescaler too narrow for selector range");
      end
   endgenerate

   logic [PRE_W-1:0] pre_q;
   logic [PRE_W-1:0] mask;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    pre_q <= '0;
      else if (!run) pre_q <= '0;
      else           pre_q <= pre_q + 1'b1;
   end

   always_comb begin
      for (int i = 0; i < PRE_W; i++) mask[i] = (i < int'(sel));
   end

   assign tick = ((pre_q & mask) == mask);
endmodule

// File: rtl/tmr_edge_det.sv
module tmr_edge_det
   import tmr_evt_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       pin,
   input  logic [1:0] mode,
   output logic       pulse
);
   logic s1_q, s2_q, s3_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s1_q <= 1'b0;
         s2_q <= 1'b0;
         s3_q <= 1'b0;
      end else begin
         s1_q <= pin;
         s2_q <= s1_q;
         s3_q <= s2_q;
      end
   end

   assign pulse = edge_hit(edge_mode_e'(mode), s2_q & ~s3_q, ~s2_q & s3_q);
endmodule

// File: rtl/tmr_cmp_chan.sv
module tmr_cmp_chan #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             tick,
   input  logic             wrap,
   input  logic [CNT_W-1:0] cnt_nxt,
   input  logic [CNT_W-1:0] cmp_val,
   input  logic             oe,
   input  logic             dflt,
   output logic [CNT_W-1:0] shadow_q,
   output logic             irq_q,
   output logic             tout_q
);
   logic hit;
   assign hit = run & tick & (cnt_nxt == shadow_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shadow_q <= '0;
         irq_q    <= 1'b0;
         tout_q   <= 1'b0;
      end else begin
         if (!run || wrap) shadow_q <= cmp_val;
         irq_q <= hit;
         if (!oe)      tout_q <= dflt;
         else if (hit) tout_q <= ~tout_q;
      end
   end
endmodule

// File: rtl/tmr_evt_cmp.sv
module tmr_evt_cmp
   import tmr_evt_pkg::*;
#(
   parameter int CNT_W  = 16,
   parameter int N_CH   = 2,
   parameter int N_PIN  = 2,
   parameter int PRE_W  = 7,
   parameter int SEL_W  = 3,
   parameter int ADDR_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [CNT_W-1:0]  bus_wdata,
   output logic [CNT_W-1:0]  bus_rdata,
   input  logic [N_PIN-1:0]  tin,
   output logic [N_PIN-1:0]  edge_pulse,
   output logic [N_CH-1:0]   irq,
   output logic [N_CH-1:0]   tout
);
   localparam int CTRL_W = SEL_W + 2;
   localparam int A_EDGE = A_CMP_BASE + N_CH;
   localparam int A_OUT  = A_EDGE + 1;

   generate
      if (N_CH < 1 || N_PIN < 1) begin : g_bad_cnt
         $error("need at least one channel and one pin");
      end
      if (CTRL_W > CNT_W || 2 * N_PIN > CNT_W || 2 * N_CH > CNT_W) begin : g_bad_w
         $error("register fields exceed data width");
      end
      if (2 ** ADDR_W < A_OUT + 1) begin : g_bad_a
         $error("address width too small for register map");
      end
   endgenerate

   logic [CTRL_W-1:0]           ctrl_q;
   logic [N_CH-1:0][CNT_W-1:0]  cmp_q;
   logic [N_CH-1:0][CNT_W-1:0]  shadow_q;
   logic [2*N_PIN-1:0]          edge_cfg_q;
   logic [2*N_CH-1:0]           out_cfg_q;
   logic [CNT_W-1:0]            cnt_q;
   logic [CNT_W-1:0]            cnt_nxt;
   logic                        run, use_ext, tick_int, tick, wrap;

   assign run     = ctrl_q[0];
   assign use_ext = ctrl_q[CTRL_W-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q     <= '0;
         cmp_q      <= '0;
         edge_cfg_q <= '0;
         out_cfg_q  <= '0;
      end else if (bus_wr) begin
         if (bus_addr == ADDR_W'(A_CTRL)) ctrl_q     <= bus_wdata[CTRL_W-1:0];
         if (bus_addr == ADDR_W'(A_EDGE)) edge_cfg_q <= bus_wdata[2*N_PIN-1:0];
         if (bus_addr == ADDR_W'(A_OUT))  out_cfg_q  <= bus_wdata[2*N_CH-1:0];
         for (int i = 0; i < N_CH; i++) begin
            if (bus_addr == ADDR_W'(A_CMP_BASE + i)) cmp_q[i] <= bus_wdata;
         end
      end
   end

   tmr_prescale #(.PRE_W(PRE_W), .SEL_W(SEL_W)) u_pre (
      .clk(clk), .rst_n(rst_n), .run(run),
      .sel(ctrl_q[SEL_W:1]), .tick(tick_int)
   );

   generate
      for (genvar p = 0; p < N_PIN; p++) begin : g_pin
         tmr_edge_det u_edge (
            .clk(clk), .rst_n(rst_n), .pin(tin[p]),
            .mode(edge_cfg_q[2*p +: 2]), .pulse(edge_pulse[p])
         );
      end
   endgenerate

   assign tick    = run & (use_ext ? edge_pulse[0] : tick_int);
   assign cnt_nxt = cnt_q + 1'b1;
   assign wrap    = tick & (cnt_q == '1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    cnt_q <= '1;
      else if (!run) cnt_q <= '1;
      else if (tick) cnt_q <= cnt_nxt;
   end

   generate
      for (genvar c = 0; c < N_CH; c++) begin : g_ch
         tmr_cmp_chan #(.CNT_W(CNT_W)) u_chan (
            .clk(clk), .rst_n(rst_n), .run(run), .tick(tick), .wrap(wrap),
            .cnt_nxt(cnt_nxt), .cmp_val(cmp_q[c]),
            .oe(out_cfg_q[2*c]), .dflt(out_cfg_q[2*c+1]),
            .shadow_q(shadow_q[c]), .irq_q(irq[c]), .tout_q(tout[c])
         );
      end
   endgenerate

   always_comb begin
      bus_rdata = '0;
      if (bus_addr == ADDR_W'(A_CTRL))  bus_rdata[CTRL_W-1:0] = ctrl_q;
      if (bus_addr == ADDR_W'(A_COUNT)) bus_rdata = run ? cnt_q : '0;
      for (int i = 0; i < N_CH; i++) begin
         if (bus_addr == ADDR_W'(A_CMP_BASE + i)) bus_rdata = cmp_q[i];
      end
      if (bus_addr == ADDR_W'(A_EDGE))  bus_rdata[2*N_PIN-1:0] = edge_cfg_q;
      if (bus_addr == ADDR_W'(A_OUT))   bus_rdata[2*N_CH-1:0]  = out_cfg_q;
   end
endmodule

// File: rtl/tmr_evt_cmp_chk.sv
module tmr_evt_cmp_chk #(
   parameter int CNT_W  = 16,
   parameter int N_CH   = 2,
   parameter int ADDR_W = 3
) (
   input logic                       clk,
   input logic                       rst_n,
   input logic                       run_q,
   input logic [CNT_W-1:0]           cnt_q,
   input logic [N_CH-1:0][CNT_W-1:0] shadow_q,
   input logic [2*N_CH-1:0]          out_cfg_q,
   input logic [ADDR_W-1:0]          bus_addr,
   input logic [CNT_W-1:0]           bus_rdata,
   input logic [N_CH-1:0]            irq,
   input logic [N_CH-1:0]            tout
);
   AST_PARK_ONES: assert property (@(posedge clk) disable iff (!rst_n)
      !run_q |=> cnt_q == '1); // R2

   AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      $past(run_q) && $past(cnt_q) == '1 && cnt_q != '1 |-> cnt_q == '0); // R2

   AST_COUNT_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      bus_addr == ADDR_W'(1) && !run_q |-> bus_rdata == '0); // R3

   generate
      for (genvar c = 0; c < N_CH; c++) begin : g_chk
         AST_IRQ_AT_SHADOW: assert property (@(posedge clk) disable iff (!rst_n)
            irq[c] |-> cnt_q == $past(shadow_q[c])); // R7

         AST_IRQ_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
            irq[c] |-> $past(run_q)); // R7

         AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            $past(run_q) && cnt_q != '0 |-> $stable(shadow_q[c])); // R5

         AST_TOUT_DEFAULT: assert property (@(posedge clk) disable iff (!rst_n)
            !out_cfg_q[2*c] |=> tout[c] == $past(out_cfg_q[2*c+1])); // R9
      end
   endgenerate
endmodule

bind tmr_evt_cmp tmr_evt_cmp_chk #(.CNT_W(CNT_W), .N_CH(N_CH), .ADDR_W(ADDR_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .run_q(run), .cnt_q(cnt_q), .shadow_q(shadow_q),
   .out_cfg_q(out_cfg_q), .bus_addr(bus_addr), .bus_rdata(bus_rdata),
   .irq(irq), .tout(tout)
);

// File: tb/tmr_evt_cmp_bench.sv
`timescale 1ns/1ps
module tmr_evt_cmp_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0;
   logic [2:0]  bus_addr = '0;
   logic [15:0] bus_wdata = '0;
   logic [1:0]  tin = '0;
   logic [15:0] bus_rdata;
   logic [1:0]  edge_pulse, irq, tout;

   int n_checks = 0;
   int n_errors = 0;

   always #10 clk = ~clk;

   tmr_evt_cmp u_tmr_evt_cmp (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tin(tin),
      .edge_pulse(edge_pulse), .irq(irq), .tout(tout)
   );

   // reference model state, derived from the requirements
   logic        m_run, m_ext;
   logic [2:0]  m_sel;
   logic [15:0] m_cmp [2];
   logic [15:0] m_shd [2];
   logic [3:0]  m_edge, m_out;
   logic [15:0] m_cnt;
   logic [6:0]  m_pre;
   logic [1:0]  m_s1, m_s2, m_s3, m_irq, m_tout;

   function automatic logic edge_fn(logic [1:0] mode, logic s2, logic s3);
      case (mode)
         2'b00:   return 1'b0;
         2'b01:   return s2 & ~s3;
         2'b10:   return ~s2 & s3;
         default: return s2 ^ s3;
      endcase
   endfunction

   function automatic logic [15:0] exp_rdata(logic [2:0] a);
      case (a)
         3'd0:    return {11'd0, m_ext, m_sel, m_run};
         3'd1:    return m_run ? m_cnt : 16'h0000;
         3'd2:    return m_cmp[0];
         3'd3:    return m_cmp[1];
         3'd4:    return {12'd0, m_edge};
         3'd5:    return {12'd0, m_out};
         default: return 16'h0000;
      endcase
   endfunction

   always @(posedge clk) begin : model
      logic [6:0]  mask;
      logic        tk, hit;
      logic [15:0] n_shd [2];
      logic [1:0]  n_irq, n_tout;
      if (!rst_n) begin
         m_run = 0; m_ext = 0; m_sel = 0; m_cmp[0] = 0; m_cmp[1] = 0;
         m_shd[0] = 0; m_shd[1] = 0; m_edge = 0; m_out = 0; m_cnt = 16'hFFFF;
         m_pre = 0; m_s1 = 0; m_s2 = 0; m_s3 = 0; m_irq = 0; m_tout = 0;
      end else begin
         mask = 7'((1 << m_sel) - 1);
         tk = m_run && (m_ext ? edge_fn(m_edge[1:0], m_s2[0], m_s3[0])
                              : ((m_pre & mask) == mask));
         for (int c = 0; c < 2; c++) begin
            hit = m_run && tk && (16'(m_cnt + 1) == m_shd[c]);
            n_irq[c] = hit;
            if (!m_out[2*c])  n_tout[c] = m_out[2*c+1];
            else if (hit)     n_tout[c] = ~m_tout[c];
            else              n_tout[c] = m_tout[c];
            n_shd[c] = (!m_run || (tk && m_cnt == 16'hFFFF)) ? m_cmp[c] : m_shd[c];
         end
         m_irq = n_irq; m_tout = n_tout; m_shd[0] = n_shd[0]; m_shd[1] = n_shd[1];
         if (!m_run)  m_cnt = 16'hFFFF;
         else if (tk) m_cnt = m_cnt + 16'd1;
         m_pre = m_run ? m_pre + 7'd1 : 7'd0;
         m_s3 = m_s2; m_s2 = m_s1; m_s1 = tin;
         if (bus_wr) begin
            case (bus_addr)
               3'd0: begin m_run = bus_wdata[0]; m_sel = bus_wdata[3:1]; m_ext = bus_wdata[4]; end
               3'd2: m_cmp[0] = bus_wdata;
               3'd3: m_cmp[1] = bus_wdata;
               3'd4: m_edge = bus_wdata[3:0];
               3'd5: m_out = bus_wdata[3:0];
               default: ;
            endcase
         end
      end
   end

   task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_errors++;
         $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic cycle();
      string rtag;
      @(negedge clk);
      if (bus_addr == 3'd1)                        rtag = m_run ? "R1 count" : "R3 count";
      else if (bus_addr == 3'd2 || bus_addr == 3'd3) rtag = "R6 cmp";
      else                                         rtag = "R10 reg";
      check(rtag, bus_rdata, exp_rdata(bus_addr));
      check("R7 irq", {14'd0, irq}, {14'd0, m_irq});
      check("R9 tout", {14'd0, tout}, {14'd0, m_tout});
      check("R8 edge", {14'd0, edge_pulse},
            {14'd0, edge_fn(m_edge[3:2], m_s2[1], m_s3[1]), edge_fn(m_edge[1:0], m_s2[0], m_s3[0])});
   endtask

   task automatic wr(logic [2:0] a, logic [15:0] d);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      cycle();
      bus_wr = 1'b0;
   endtask

   initial begin : watchdog
      #(20ns * 150000);
      n_errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end

   initial begin : stim
      logic [15:0] hits [2];
      int nh;
      void'($urandom(32'h1d5e_0c3a));
      repeat (3) cycle();
      // reset state
      for (int a = 0; a < 8; a++) begin
         bus_addr = 3'(a); #1;
         check("R4 reset reg", bus_rdata, 16'h0000);
      end
      check("R4 reset irq/tout", {12'd0, irq, tout}, 16'h0000);
      rst_n = 1'b1;
      cycle();
      // first step after enable lands on zero
      wr(3'd2, 16'd3);
      wr(3'd0, 16'h0001);
      bus_addr = 3'd1;
      cycle();
      check("R2 first step", bus_rdata, 16'h0000);
      wr(3'd1, 16'h1234);   // COUNT is read-only
      bus_addr = 3'd1;
      repeat (4) cycle();
      // constrained random phase
      for (int n = 0; n < 4000; n++) begin
         bus_wr = ($urandom % 8) == 0;
         bus_addr = 3'($urandom % 8);
         case (bus_addr)
            3'd0: bus_wdata = {11'd0, 1'($urandom), 3'($urandom % 3), 1'(($urandom % 5) != 0)};
            3'd2, 3'd3: bus_wdata = 16'($urandom % 48);
            default: bus_wdata = 16'($urandom);
         endcase
         if ($urandom % 3 == 0) tin = tin ^ 2'($urandom);
         cycle();
      end
      bus_wr = 1'b0;
      // full rollover: mid-period compare write takes effect after wrap
      wr(3'd0, 16'h0000);
      wr(3'd2, 16'd5);
      wr(3'd5, 16'h0001);
      wr(3'd0, 16'h0001);
      wr(3'd2, 16'd9);
      bus_addr = 3'd1;
      nh = 0;
      for (int n = 0; n < 65560; n++) begin
         cycle();
         if (irq[0] && nh < 2) begin
            hits[nh] = bus_rdata;
            nh++;
         end
      end
      check("R5 match count", 16'(nh), 16'd2);
      if (nh == 2) begin
         check("R5 old shadow used", hits[0], 16'd5);
         check("R5 new shadow after wrap", hits[1], 16'd9);
      end
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end
endmodule